// File: doc/BRIEF.md
# Reset Command Packet Decoder

This block watches the payload bytes of incoming command packets, one byte per beat, and picks out the two reset commands. The first payload byte names the slot the board sits in. The second byte is the command type. Two type codes are recognised, and they differ only in their top bit. For a hard reset the block raises a one-cycle strobe that starts a reset of the Ethernet controller. For a soft reset it takes a six-byte partner MAC address and a peripheral mask from the bytes that follow. It then raises a one-cycle soft-reset strobe, together with separate ADC and DAC reset strobes chosen by the mask.

A command is acted on when its packet's last beat arrives. Any padding that sits between the parameters and the end of the packet is consumed and ignored. After either command the block waits for the external reset sequencer to report completion. It then issues a one-cycle request for a status reply. Executing the resets and building the reply are done elsewhere.

Top module: `rstcmd_decoder`

## Requirements
- R1: After a synchronous reset, every strobe is low and `slot_loc` and `partner_mac` read zero.
- R2: The byte on the first beat of a packet (`in_first` high) is the slot location. It appears on `slot_loc` in the same cycle as the strobe of the command it arrived with.
- R3: A packet whose second byte is 0x52 and that is at least 2 bytes long raises `hard_rst_stb` for exactly one cycle. This happens in the cycle after its last beat is accepted.
- R4: A packet whose second byte is 0xD2 and that is at least 9 bytes long raises `soft_rst_stb` for one cycle, in the cycle after its last beat. In that same cycle `partner_mac` takes payload bytes 2..7, with byte 2 in bits 47:40 and byte 7 in bits 7:0. `partner_mac` changes at no other time.
- R5: With a soft strobe, `adc_rst_stb` follows bit 1 of payload byte 8 and `dac_rst_stb` follows bit 0. Bits 7..2 of that byte have no effect, and neither strobe rises without the soft strobe.
- R6: A 0xD2 packet that ends before its mask byte produces no strobe and leaves `partner_mac` unchanged.
- R7: Any other type code, or a one-byte packet, produces no strobe.
- R8: After a command, `status_req_stb` pulses for one cycle in the cycle after `seq_done` is sampled high. `seq_done` seen while no command is pending has no effect.
- R9: While a command waits for `seq_done`, further commands are dropped without any strobe or register change.
- R10: A beat with `in_first` high restarts parsing at byte 0, even in the middle of a packet. Beats that arrive after a last beat and before the next first beat are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Payload byte valid this cycle |
| in_data | input | 8 | Payload byte |
| in_first | input | 1 | Beat is payload byte 0 |
| in_last | input | 1 | Beat is the final payload byte |
| seq_done | input | 1 | Reset sequencer finished the commanded reset |
| hard_rst_stb | output | 1 | One-cycle hard reset request |
| soft_rst_stb | output | 1 | One-cycle soft reset request |
| adc_rst_stb | output | 1 | ADC reset request, with soft strobe |
| dac_rst_stb | output | 1 | DAC reset request, with soft strobe |
| status_req_stb | output | 1 | One-cycle status reply request |
| slot_loc | output | 8 | Slot location of the last accepted command |
| partner_mac | output | 48 | Partner MAC address from the last soft reset |

## Verification
The bench uses the default parameters: a six-byte partner address, which places the mask byte at payload index 8, and the two type codes 0x52 and 0xD2. With these values the important frame lengths stay short: a soft packet cut off one byte before the mask, a packet that ends exactly on the mask byte, and padded packets. Each of these takes only a few beats, so every truncation point, a restart part-way through a packet, and drops while a command is pending are all driven directly.

// File: rtl/rstcmd_pkg.sv
package rstcmd_pkg;
    localparam int BYTE_W = 8;

    // Payload positions that the command format fixes.
    localparam int LOC_IDX  = 0;
    localparam int TYPE_IDX = 1;
    localparam int MAC_IDX  = 2;

    // Mask bit positions for the peripheral resets.
    localparam int ADC_BIT = 1;
    localparam int DAC_BIT = 0;

    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_HARD = 2'd1,
        CMD_SOFT = 2'd2
    } cmd_kind_e;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_WAIT = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic adc;
        logic dac;
    } periph_mask_t;

    function automatic int mask_index(input int mac_bytes);
        return MAC_IDX + mac_bytes;
    endfunction
endpackage

// File: rtl/rstcmd_octet_reg.sv
module rstcmd_octet_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= d;
    end
endmodule

// File: rtl/rstcmd_parser.sv
module rstcmd_parser
    import rstcmd_pkg::*;
#(
    parameter int          MAC_BYTES = 6,
    parameter logic [7:0]  TYPE_HARD = 8'h52,
    parameter logic [7:0]  TYPE_SOFT = 8'hD2,
    localparam int         MAC_W     = MAC_BYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_first,
    input  logic              in_last,
    output cmd_kind_e         evt_kind,
    output logic [BYTE_W-1:0] evt_loc,
    output logic [MAC_W-1:0]  evt_mac,
    output periph_mask_t      evt_mask
);
    localparam int MASK_IDX = mask_index(MAC_BYTES);
    localparam int CNT_MAX  = MASK_IDX + 1;
    localparam int CNT_W    = $clog2(CNT_MAX + 1);

    logic              in_pkt;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  idx;
    logic              beat_ok;
    logic [BYTE_W-1:0] loc_q;
    logic [BYTE_W-1:0] type_q;
    logic [BYTE_W-1:0] cur_type;
    periph_mask_t      mask_q;
    periph_mask_t      cur_mask;

    // A beat counts only inside a framed packet or when it opens a new one.
    assign beat_ok  = in_valid && (in_first || in_pkt);
    assign idx      = in_first ? '0 : cnt;
    assign cur_type = (idx == CNT_W'(TYPE_IDX)) ? in_data : type_q;
    assign cur_mask = (idx == CNT_W'(MASK_IDX))
                      ? periph_mask_t'({in_data[ADC_BIT], in_data[DAC_BIT]})
                      : mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_pkt <= 1'b0;
            cnt    <= '0;
        end else if (beat_ok) begin
            in_pkt <= !in_last;
            cnt    <= (idx >= CNT_W'(CNT_MAX)) ? CNT_W'(CNT_MAX) : idx + 1'b1;
        end
    end

    rstcmd_octet_reg #(.W(BYTE_W)) u_loc (
        .clk (clk), .rst (rst),
        .load(beat_ok && idx == CNT_W'(LOC_IDX)),
        .d   (in_data), .q(loc_q)
    );

    rstcmd_octet_reg #(.W(BYTE_W)) u_type (
        .clk (clk), .rst (rst),
        .load(beat_ok && idx == CNT_W'(TYPE_IDX)),
        .d   (in_data), .q(type_q)
    );

    rstcmd_octet_reg #(.W(2)) u_mask (
        .clk (clk), .rst (rst),
        .load(beat_ok && idx == CNT_W'(MASK_IDX)),
        .d   (cur_mask), .q(mask_q)
    );

    // One shadow register per address byte; first byte on the wire is most significant.
    for (genvar g = 0; g < MAC_BYTES; g++) begin : g_mac
        logic [BYTE_W-1:0] oct_q;
        rstcmd_octet_reg #(.W(BYTE_W)) u_oct (
            .clk (clk), .rst (rst),
            .load(beat_ok && idx == CNT_W'(MAC_IDX + g)),
            .d   (in_data), .q(oct_q)
        );
        assign evt_mac[MAC_W-1-g*BYTE_W -: BYTE_W] = oct_q;
    end

    always_comb begin
        evt_kind = CMD_NONE;
        if (beat_ok && in_last && idx >= CNT_W'(TYPE_IDX)) begin
            if (cur_type == TYPE_HARD)
                evt_kind = CMD_HARD;
            else if (cur_type == TYPE_SOFT && idx >= CNT_W'(MASK_IDX))
                evt_kind = CMD_SOFT;
        end
    end

    assign evt_loc  = loc_q;
    assign evt_mask = cur_mask;
endmodule

// File: rtl/rstcmd_sequencer.sv
module rstcmd_sequencer
    import rstcmd_pkg::*;
#(
    parameter int MAC_W = 48
) (
    input  logic              clk,
    input  logic              rst,
    input  cmd_kind_e         evt_kind,
    input  logic [BYTE_W-1:0] evt_loc,
    input  logic [MAC_W-1:0]  evt_mac,
    input  periph_mask_t      evt_mask,
    input  logic              seq_done,
    output logic              hard_rst_stb,
    output logic              soft_rst_stb,
    output logic              adc_rst_stb,
    output logic              dac_rst_stb,
    output logic              status_req_stb,
    output logic [BYTE_W-1:0] slot_loc,
    output logic [MAC_W-1:0]  partner_mac
);
    seq_state_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state          <= SEQ_IDLE;
            hard_rst_stb   <= 1'b0;
            soft_rst_stb   <= 1'b0;
            adc_rst_stb    <= 1'b0;
            dac_rst_stb    <= 1'b0;
            status_req_stb <= 1'b0;
            slot_loc       <= '0;
            partner_mac    <= '0;
        end else begin
            hard_rst_stb   <= 1'b0;
            soft_rst_stb   <= 1'b0;
            adc_rst_stb    <= 1'b0;
            dac_rst_stb    <= 1'b0;
            status_req_stb <= 1'b0;
            case (state)
                SEQ_IDLE: begin
                    if (evt_kind == CMD_HARD) begin
                        hard_rst_stb <= 1'b1;
                        slot_loc     <= evt_loc;
                        state        <= SEQ_WAIT;
                    end else if (evt_kind == CMD_SOFT) begin
                        soft_rst_stb <= 1'b1;
                        adc_rst_stb  <= evt_mask.adc;
                        dac_rst_stb  <= evt_mask.dac;
                        slot_loc     <= evt_loc;
                        partner_mac  <= evt_mac;
                        state        <= SEQ_WAIT;
                    end
                end
                SEQ_WAIT: begin
                    if (seq_done) begin
                        status_req_stb <= 1'b1;
                        state          <= SEQ_IDLE;
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/rstcmd_decoder.sv
module rstcmd_decoder
    import rstcmd_pkg::*;
#(
    parameter int          MAC_BYTES = 6,
    parameter logic [7:0]  TYPE_HARD = 8'h52,
    parameter logic [7:0]  TYPE_SOFT = 8'hD2,
    localparam int         MAC_W     = MAC_BYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_first,
    input  logic              in_last,
    input  logic              seq_done,
    output logic              hard_rst_stb,
    output logic              soft_rst_stb,
    output logic              adc_rst_stb,
    output logic              dac_rst_stb,
    output logic              status_req_stb,
    output logic [BYTE_W-1:0] slot_loc,
    output logic [MAC_W-1:0]  partner_mac
);
    cmd_kind_e         evt_kind;
    logic [BYTE_W-1:0] evt_loc;
    logic [MAC_W-1:0]  evt_mac;
    periph_mask_t      evt_mask;

    rstcmd_parser #(
        .MAC_BYTES(MAC_BYTES), .TYPE_HARD(TYPE_HARD), .TYPE_SOFT(TYPE_SOFT)
    ) u_parser (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_data(in_data),
        .in_first(in_first), .in_last(in_last),
        .evt_kind(evt_kind), .evt_loc(evt_loc),
        .evt_mac(evt_mac), .evt_mask(evt_mask)
    );

    rstcmd_sequencer #(.MAC_W(MAC_W)) u_seq (
        .clk(clk), .rst(rst),
        .evt_kind(evt_kind), .evt_loc(evt_loc),
        .evt_mac(evt_mac), .evt_mask(evt_mask),
        .seq_done(seq_done),
        .hard_rst_stb(hard_rst_stb), .soft_rst_stb(soft_rst_stb),
        .adc_rst_stb(adc_rst_stb), .dac_rst_stb(dac_rst_stb),
        .status_req_stb(status_req_stb),
        .slot_loc(slot_loc), .partner_mac(partner_mac)
    );
endmodule

// File: rtl/rstcmd_decoder_chk.sv
module rstcmd_decoder_chk #(
    parameter int MAC_W = 48
) (
    input logic             clk,
    input logic             rst,
    input logic             seq_done,
    input logic             hard_rst_stb,
    input logic             soft_rst_stb,
    input logic             adc_rst_stb,
    input logic             dac_rst_stb,
    input logic             status_req_stb,
    input logic [MAC_W-1:0] partner_mac
);
    // R3
    hard_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        hard_rst_stb |=> !hard_rst_stb);
    // R4
    soft_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        soft_rst_stb |=> !soft_rst_stb);
    // R3
    kind_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(hard_rst_stb && soft_rst_stb));
    // R4
    mac_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !soft_rst_stb |-> $stable(partner_mac));
    // R5
    adc_with_soft_chk: assert property (@(posedge clk) disable iff (rst)
        adc_rst_stb |-> soft_rst_stb);
    // R5
    dac_with_soft_chk: assert property (@(posedge clk) disable iff (rst)
        dac_rst_stb |-> soft_rst_stb);
    // R8
    status_after_done_chk: assert property (@(posedge clk) disable iff (rst)
        status_req_stb |-> $past(seq_done));
    // R8
    status_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        status_req_stb |=> !status_req_stb);
    // R9
    no_strobe_while_status_chk: assert property (@(posedge clk) disable iff (rst)
        status_req_stb |-> !(hard_rst_stb || soft_rst_stb));
endmodule

bind rstcmd_decoder rstcmd_decoder_chk #(.MAC_W(MAC_W)) u_chk (
    .clk(clk), .rst(rst), .seq_done(seq_done),
    .hard_rst_stb(hard_rst_stb), .soft_rst_stb(soft_rst_stb),
    .adc_rst_stb(adc_rst_stb), .dac_rst_stb(dac_rst_stb),
    .status_req_stb(status_req_stb), .partner_mac(partner_mac)
);

// File: tb/rstcmd_decoder_tb.sv
module rstcmd_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_first = 1'b0;
    logic        in_last = 1'b0;
    logic        seq_done = 1'b0;
    logic        hard_rst_stb, soft_rst_stb, adc_rst_stb, dac_rst_stb, status_req_stb;
    logic [7:0]  slot_loc;
    logic [47:0] partner_mac;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] pkt [0:15];

    always #10 clk = ~clk;

    rstcmd_decoder dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_first(in_first), .in_last(in_last), .seq_done(seq_done),
        .hard_rst_stb(hard_rst_stb), .soft_rst_stb(soft_rst_stb),
        .adc_rst_stb(adc_rst_stb), .dac_rst_stb(dac_rst_stb),
        .status_req_stb(status_req_stb), .slot_loc(slot_loc),
        .partner_mac(partner_mac)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Sends pkt[0..n-1]; with first_flag low the opening beat carries no start flag.
    // Returns at the negedge after the last beat was accepted.
    task automatic send(input int n, input bit first_flag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = pkt[i];
            in_first = (i == 0) && first_flag;
            in_last  = (i == n - 1);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_first = 1'b0;
        in_last  = 1'b0;
    endtask

    function automatic logic [4:0] strobes();
        return {hard_rst_stb, soft_rst_stb, adc_rst_stb, dac_rst_stb, status_req_stb};
    endfunction

    task automatic give_done(input bit expect_status, input string req);
        @(negedge clk);
        seq_done = 1'b1;
        @(negedge clk);
        seq_done = 1'b0;
        chk(req, status_req_stb, expect_status);
        @(negedge clk);
        chk(req, status_req_stb, 1'b0);
    endtask

    task automatic fill_soft(input logic [7:0] loc, input logic [47:0] mac, input logic [7:0] mask);
        pkt[0] = loc;
        pkt[1] = 8'hD2;
        for (int i = 0; i < 6; i++) pkt[2+i] = mac[47-8*i -: 8];
        pkt[8] = mask;
    endtask

    task automatic t_reset();
        chk("R1 strobes", strobes(), 5'b0);
        chk("R1 slot", slot_loc, 8'h00);
        chk("R1 mac", partner_mac, 48'h0);
    endtask

    task automatic t_hard();
        pkt[0] = 8'h05; pkt[1] = 8'h52; pkt[2] = 8'h00; pkt[3] = 8'h52; pkt[4] = 8'hFF;
        send(5, 1'b1);
        chk("R3 hard strobe", strobes(), 5'b10000);
        chk("R2 slot", slot_loc, 8'h05);
        @(negedge clk);
        chk("R3 single cycle", strobes(), 5'b00000);
        chk("R8 no status before done", status_req_stb, 1'b0);
        give_done(1'b1, "R8 status after done");
    endtask

    task automatic t_soft_adc();
        fill_soft(8'h07, 48'h112233445566, 8'hFE);
        send(9, 1'b1);
        chk("R4 soft strobe", strobes(), 5'b01100);
        chk("R4 mac", partner_mac, 48'h112233445566);
        chk("R2 slot soft", slot_loc, 8'h07);
        @(negedge clk);
        chk("R4 single cycle", strobes(), 5'b00000);
        give_done(1'b1, "R8 soft status");
    endtask

    task automatic t_soft_dac_padded();
        fill_soft(8'h09, 48'hAABBCCDDEEFF, 8'h01);
        pkt[9] = 8'h52; pkt[10] = 8'hD2;
        send(11, 1'b1);
        chk("R5 dac only", strobes(), 5'b01010);
        chk("R4 mac padded", partner_mac, 48'hAABBCCDDEEFF);
        give_done(1'b1, "R8 status");
    endtask

    task automatic t_soft_short();
        fill_soft(8'h0C, 48'h010203040506, 8'h03);
        send(8, 1'b1);
        chk("R6 no strobe", strobes(), 5'b00000);
        @(negedge clk);
        chk("R6 mac kept", partner_mac, 48'hAABBCCDDEEFF);
        chk("R6 slot kept", slot_loc, 8'h09);
        give_done(1'b0, "R8 done while idle ignored");
    endtask

    task automatic t_unknown();
        pkt[0] = 8'h02; pkt[1] = 8'h53; pkt[2] = 8'h00;
        send(3, 1'b1);
        chk("R7 type 0x53", strobes(), 5'b00000);
        pkt[0] = 8'h02; pkt[1] = 8'h12;
        send(2, 1'b1);
        chk("R7 type 0x12", strobes(), 5'b00000);
        pkt[0] = 8'h52;
        send(1, 1'b1);
        chk("R7 one byte", strobes(), 5'b00000);
        chk("R7 slot kept", slot_loc, 8'h09);
    endtask

    task automatic t_busy();
        pkt[0] = 8'h21; pkt[1] = 8'h52;
        send(2, 1'b1);
        chk("R3 short hard", strobes(), 5'b10000);
        fill_soft(8'h22, 48'hDEADBEEF0001, 8'h03);
        send(9, 1'b1);
        chk("R9 dropped", strobes(), 5'b00000);
        @(negedge clk);
        chk("R9 mac kept", partner_mac, 48'hAABBCCDDEEFF);
        chk("R9 slot kept", slot_loc, 8'h21);
        give_done(1'b1, "R8 status after busy");
    endtask

    task automatic t_restart();
        pkt[0] = 8'h30; pkt[1] = 8'hD2; pkt[2] = 8'h44; pkt[3] = 8'h55;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_data = pkt[i]; in_first = (i == 0); in_last = 1'b0;
        end
        pkt[0] = 8'h31; pkt[1] = 8'h52;
        send(2, 1'b1);
        chk("R10 restart hard", strobes(), 5'b10000);
        chk("R10 restart slot", slot_loc, 8'h31);
        give_done(1'b1, "R8 status");
        pkt[0] = 8'h40; pkt[1] = 8'h52; pkt[2] = 8'h00;
        send(3, 1'b0);
        chk("R10 stray beats", strobes(), 5'b00000);
        chk("R10 stray slot", slot_loc, 8'h31);
    endtask

    bit finished = 1'b0;

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_hard();
        t_soft_adc();
        t_soft_dac_padded();
        t_soft_short();
        t_unknown();
        t_busy();
        t_restart();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule